// File: doc/BRIEF.md
# Running Extremes Tracker for Supply and Temperature Readings

This block sits behind a set of measurement converters and keeps the highest and lowest values it has seen. Each of sixteen supply rails delivers a voltage reading and a current reading, and each of five thermal sensors delivers a temperature reading. All of them arrive together, qualified by a single sample strobe. On every strobe, each rail updates its highest voltage, its lowest voltage and its highest current. Each sensor updates its highest temperature.

A rail whose voltage reading is exactly zero is treated as switched off. Its three stored extremes stay as they are, so a rail that is powered down does not drag its stored minimum to zero. Temperature has no such rule.

Host software reaches every stored extreme through a small register port. Reads are combinational. A write overwrites the addressed register, which lets software clear or re-arm a tracker at any time. Readings are 16-bit unsigned values: voltage in millivolts up to 32767, and temperature in hundredths of a degree, so 2500 means 25.00 C.

Top module: `extreme_tracker`

## Requirements
- R1: After reset, every voltage minimum reads 0x7FFF, and every voltage peak, current peak and temperature peak reads zero.
- R2: On a sample strobe with a nonzero rail voltage, the rail's voltage peak takes the reading only if the reading is strictly greater than the stored peak.
- R3: On a sample strobe with a nonzero rail voltage, the rail's voltage minimum takes the reading only if the reading is strictly smaller than the stored minimum.
- R4: On a sample strobe with a nonzero rail voltage, the rail's current peak takes the current reading only if that reading is strictly greater than the stored current peak.
- R5: A rail whose voltage reading is zero during a strobe leaves its voltage peak, voltage minimum and current peak unchanged, whatever its current reading.
- R6: On every strobe, each temperature peak takes its reading if the reading is strictly greater, whatever the value, zero included.
- R7: Without a sample strobe, no stored extreme changes except through a host write.
- R8: The host address is 6 bits. Bits [5:4] select the kind: 0 is voltage peak, 1 is voltage minimum, 2 is current peak, 3 is temperature peak. Bits [3:0] select the channel. A write stores the write data in the addressed register, and the read data always shows the addressed register.
- R9: When a host write and a sample update target the same register in the same cycle, the register takes the host data. The other registers of that channel still take their sample updates.
- R10: A temperature address with channel 5 to 15 maps to no register. A write there changes nothing, and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Strobe that qualifies all readings in this cycle |
| vin_bus | input | 256 | Rail voltage readings; rail k occupies bits [16k+15:16k] |
| iin_bus | input | 256 | Rail current readings; rail k occupies bits [16k+15:16k] |
| tin_bus | input | 80 | Temperature readings; sensor k occupies bits [16k+15:16k] |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 6 | Host register address: kind in [5:4], channel in [3:0] |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the addressed register, zero when unmapped |

## Verification
Two functions can fall in the same cycle: a host write to an extreme register, and a sample strobe that would update that same register. The bench provokes this on one rail. It writes a small voltage peak in the same cycle as a larger sample arrives on that rail. It then reads back the voltage peak, which must hold the host value, and the voltage minimum and current peak, which must hold the sample values. The checker confirms, at every cycle, that a write strobe on a register is followed by the host data in that register, whatever the sample did.

// File: rtl/ext_pkg.sv
package ext_pkg;

  localparam int unsigned DW = 16;

  typedef logic [DW-1:0] rd_t;

  typedef enum logic [1:0] {
    K_VPK  = 2'd0,
    K_VMIN = 2'd1,
    K_IPK  = 2'd2,
    K_TPK  = 2'd3
  } reg_kind_e;

  function automatic logic beats_high(input rd_t cur, input rd_t nw);
    return nw > cur;
  endfunction

  function automatic logic beats_low(input rd_t cur, input rd_t nw);
    return nw < cur;
  endfunction

  function automatic logic rail_on(input rd_t v);
    return v != '0;
  endfunction

endpackage

// File: rtl/ext_pwr_lane.sv
module ext_pwr_lane
  import ext_pkg::*;
#(
  parameter rd_t VMIN_INIT = 16'h7FFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  rd_t  v_in,
  input  rd_t  i_in,
  input  logic wr_vpk,
  input  logic wr_vmin,
  input  logic wr_ipk,
  input  rd_t  wdata,
  output rd_t  vpk_q,
  output rd_t  vmin_q,
  output rd_t  ipk_q,
  output logic vpk_upd,
  output logic vmin_upd,
  output logic ipk_upd
);

  logic live;

  assign live     = smp_valid && rail_on(v_in);
  assign vpk_upd  = live && beats_high(vpk_q, v_in);
  assign vmin_upd = live && beats_low(vmin_q, v_in);
  assign ipk_upd  = live && beats_high(ipk_q, i_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpk_q  <= '0;
      vmin_q <= VMIN_INIT;
      ipk_q  <= '0;
    end else begin
      if (wr_vpk)        vpk_q <= wdata;
      else if (vpk_upd)  vpk_q <= v_in;
      if (wr_vmin)       vmin_q <= wdata;
      else if (vmin_upd) vmin_q <= v_in;
      if (wr_ipk)        ipk_q <= wdata;
      else if (ipk_upd)  ipk_q <= i_in;
    end
  end

endmodule

// File: rtl/ext_tmp_lane.sv
module ext_tmp_lane
  import ext_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  rd_t  t_in,
  input  logic wr_tpk,
  input  rd_t  wdata,
  output rd_t  tpk_q,
  output logic tpk_upd
);

  assign tpk_upd = smp_valid && beats_high(tpk_q, t_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tpk_q <= '0;
    else if (wr_tpk)  tpk_q <= wdata;
    else if (tpk_upd) tpk_q <= t_in;
  end

endmodule

// File: rtl/ext_host_port.sv
module ext_host_port
  import ext_pkg::*;
#(
  parameter int unsigned N_PWR = 16,
  parameter int unsigned N_TMP = 5,
  parameter int unsigned CH_W  = 4
) (
  input  logic              wr_en,
  input  logic [CH_W+1:0]   addr,
  input  rd_t               vpk_arr  [N_PWR],
  input  rd_t               vmin_arr [N_PWR],
  input  rd_t               ipk_arr  [N_PWR],
  input  rd_t               tpk_arr  [N_TMP],
  output logic [N_PWR-1:0]  wr_vpk,
  output logic [N_PWR-1:0]  wr_vmin,
  output logic [N_PWR-1:0]  wr_ipk,
  output logic [N_TMP-1:0]  wr_tpk,
  output rd_t               rdata
);

  reg_kind_e        kind;
  logic [CH_W-1:0]  ch;

  assign kind = reg_kind_e'(addr[CH_W+1:CH_W]);
  assign ch   = addr[CH_W-1:0];

  for (genvar p = 0; p < N_PWR; p++) begin : g_pwr_dec
    logic hit;
    assign hit        = wr_en && (ch == CH_W'(p));
    assign wr_vpk[p]  = hit && (kind == K_VPK);
    assign wr_vmin[p] = hit && (kind == K_VMIN);
    assign wr_ipk[p]  = hit && (kind == K_IPK);
  end

  for (genvar t = 0; t < N_TMP; t++) begin : g_tmp_dec
    assign wr_tpk[t] = wr_en && (kind == K_TPK) && (ch == CH_W'(t));
  end

  always_comb begin
    rdata = '0;
    unique case (kind)
      K_VPK: for (int k = 0; k < N_PWR; k++) if (ch == CH_W'(k)) rdata = vpk_arr[k];
      K_VMIN: for (int k = 0; k < N_PWR; k++) if (ch == CH_W'(k)) rdata = vmin_arr[k];
      K_IPK: for (int k = 0; k < N_PWR; k++) if (ch == CH_W'(k)) rdata = ipk_arr[k];
      K_TPK: for (int k = 0; k < N_TMP; k++) if (ch == CH_W'(k)) rdata = tpk_arr[k];
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/extreme_tracker.sv
module extreme_tracker
  import ext_pkg::*;
#(
  parameter int unsigned N_PWR     = 16,
  parameter int unsigned N_TMP     = 5,
  parameter rd_t         VMIN_INIT = 16'h7FFF,
  localparam int unsigned MAXN     = (N_PWR > N_TMP) ? N_PWR : N_TMP,
  localparam int unsigned CH_W     = ($clog2(MAXN) < 1) ? 1 : $clog2(MAXN),
  localparam int unsigned AW       = CH_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [N_PWR*DW-1:0] vin_bus,
  input  logic [N_PWR*DW-1:0] iin_bus,
  input  logic [N_TMP*DW-1:0] tin_bus,
  input  logic               host_wr_en,
  input  logic [AW-1:0]      host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata
);

  rd_t v_arr    [N_PWR];
  rd_t i_arr    [N_PWR];
  rd_t t_arr    [N_TMP];
  rd_t vpk_arr  [N_PWR];
  rd_t vmin_arr [N_PWR];
  rd_t ipk_arr  [N_PWR];
  rd_t tpk_arr  [N_TMP];

  logic [N_PWR-1:0] wr_vpk, wr_vmin, wr_ipk;
  logic [N_TMP-1:0] wr_tpk;
  logic [N_PWR-1:0] vpk_upd, vmin_upd, ipk_upd;
  logic [N_TMP-1:0] tpk_upd;

  for (genvar p = 0; p < N_PWR; p++) begin : g_pwr
    assign v_arr[p] = vin_bus[p*DW +: DW];
    assign i_arr[p] = iin_bus[p*DW +: DW];

    ext_pwr_lane #(.VMIN_INIT(VMIN_INIT)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(smp_valid),
      .v_in     (v_arr[p]),
      .i_in     (i_arr[p]),
      .wr_vpk   (wr_vpk[p]),
      .wr_vmin  (wr_vmin[p]),
      .wr_ipk   (wr_ipk[p]),
      .wdata    (host_wdata),
      .vpk_q    (vpk_arr[p]),
      .vmin_q   (vmin_arr[p]),
      .ipk_q    (ipk_arr[p]),
      .vpk_upd  (vpk_upd[p]),
      .vmin_upd (vmin_upd[p]),
      .ipk_upd  (ipk_upd[p])
    );
  end

  for (genvar t = 0; t < N_TMP; t++) begin : g_tmp
    assign t_arr[t] = tin_bus[t*DW +: DW];

    ext_tmp_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(smp_valid),
      .t_in     (t_arr[t]),
      .wr_tpk   (wr_tpk[t]),
      .wdata    (host_wdata),
      .tpk_q    (tpk_arr[t]),
      .tpk_upd  (tpk_upd[t])
    );
  end

  ext_host_port #(.N_PWR(N_PWR), .N_TMP(N_TMP), .CH_W(CH_W)) u_host (
    .wr_en   (host_wr_en),
    .addr    (host_addr),
    .vpk_arr (vpk_arr),
    .vmin_arr(vmin_arr),
    .ipk_arr (ipk_arr),
    .tpk_arr (tpk_arr),
    .wr_vpk  (wr_vpk),
    .wr_vmin (wr_vmin),
    .wr_ipk  (wr_ipk),
    .wr_tpk  (wr_tpk),
    .rdata   (host_rdata)
  );

endmodule

// File: rtl/ext_tracker_checker.sv
module ext_tracker_checker
  import ext_pkg::*;
#(
  parameter int unsigned N_PWR     = 16,
  parameter int unsigned N_TMP     = 5,
  parameter rd_t         VMIN_INIT = 16'h7FFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             host_wr_en,
  input rd_t              host_wdata,
  input rd_t              v_arr    [N_PWR],
  input rd_t              i_arr    [N_PWR],
  input rd_t              t_arr    [N_TMP],
  input rd_t              vpk_arr  [N_PWR],
  input rd_t              vmin_arr [N_PWR],
  input rd_t              ipk_arr  [N_PWR],
  input rd_t              tpk_arr  [N_TMP],
  input logic [N_PWR-1:0] wr_vpk,
  input logic [N_PWR-1:0] wr_vmin,
  input logic [N_PWR-1:0] wr_ipk,
  input logic [N_TMP-1:0] wr_tpk,
  input logic [N_PWR-1:0] vpk_upd,
  input logic [N_PWR-1:0] vmin_upd,
  input logic [N_PWR-1:0] ipk_upd,
  input logic [N_TMP-1:0] tpk_upd
);

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_vpk, wr_vmin, wr_ipk, wr_tpk}));

  assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr_en |-> ({wr_vpk, wr_vmin, wr_ipk, wr_tpk} == '0));

  for (genvar k = 0; k < N_PWR; k++) begin : g_pc
    assert_rst_vmin_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (vmin_arr[k] == VMIN_INIT && vpk_arr[k] == '0 && ipk_arr[k] == '0));

    assert_vpk_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vpk_upd[k] && !wr_vpk[k]) |=> vpk_arr[k] == $past(v_arr[k]));

    assert_vmin_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vmin_upd[k] && !wr_vmin[k]) |=> vmin_arr[k] == $past(v_arr[k]));

    assert_ipk_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ipk_upd[k] && !wr_ipk[k]) |=> ipk_arr[k] == $past(i_arr[k]));

    assert_dead_rail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (v_arr[k] == '0 && !wr_vpk[k] && !wr_vmin[k] && !wr_ipk[k])
      |=> ($stable(vpk_arr[k]) && $stable(vmin_arr[k]) && $stable(ipk_arr[k])));

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && !host_wr_en)
      |=> ($stable(vpk_arr[k]) && $stable(vmin_arr[k]) && $stable(ipk_arr[k])));

    assert_vpk_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vpk[k] |=> vpk_arr[k] == $past(host_wdata));

    assert_vmin_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vmin[k] |=> vmin_arr[k] == $past(host_wdata));

    assert_ipk_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ipk[k] |=> ipk_arr[k] == $past(host_wdata));
  end

  for (genvar j = 0; j < N_TMP; j++) begin : g_tc
    assert_rst_tpk_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> tpk_arr[j] == '0);

    assert_tpk_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tpk_upd[j] && !wr_tpk[j]) |=> tpk_arr[j] == $past(t_arr[j]));

    assert_tpk_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_tpk[j] |=> tpk_arr[j] >= $past(tpk_arr[j]));

    assert_tpk_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tpk[j] |=> tpk_arr[j] == $past(host_wdata));
  end

endmodule

bind extreme_tracker ext_tracker_checker #(
  .N_PWR(N_PWR), .N_TMP(N_TMP), .VMIN_INIT(VMIN_INIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .host_wr_en(host_wr_en),
  .host_wdata(host_wdata),
  .v_arr     (v_arr),
  .i_arr     (i_arr),
  .t_arr     (t_arr),
  .vpk_arr   (vpk_arr),
  .vmin_arr  (vmin_arr),
  .ipk_arr   (ipk_arr),
  .tpk_arr   (tpk_arr),
  .wr_vpk    (wr_vpk),
  .wr_vmin   (wr_vmin),
  .wr_ipk    (wr_ipk),
  .wr_tpk    (wr_tpk),
  .vpk_upd   (vpk_upd),
  .vmin_upd  (vmin_upd),
  .ipk_upd   (ipk_upd),
  .tpk_upd   (tpk_upd)
);

// File: tb/extreme_tracker_bench.sv
module extreme_tracker_bench;

  localparam int NP = 16;
  localparam int NT = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           smp_valid = 1'b0;
  logic [NP*16-1:0] vin_bus = '0;
  logic [NP*16-1:0] iin_bus = '0;
  logic [NT*16-1:0] tin_bus = '0;
  logic           host_wr_en = 1'b0;
  logic [5:0]     host_addr = '0;
  logic [15:0]    host_wdata = '0;
  logic [15:0]    host_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  extreme_tracker u_extreme_tracker (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .vin_bus(vin_bus), .iin_bus(iin_bus), .tin_bus(tin_bus),
    .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  // kind codes from R8
  localparam logic [1:0] KVP = 2'd0, KVM = 2'd1, KIP = 2'd2, KTP = 2'd3;

  // {rail, voltage, current, exp vpeak, exp vmin, exp ipeak}
  localparam int NV = 8;
  localparam logic [83:0] VEC [NV] = '{
    {4'd3, 16'd1000,  16'd50,  16'd1000,  16'd1000, 16'd50},
    {4'd3, 16'd1200,  16'd40,  16'd1200,  16'd1000, 16'd50},
    {4'd3, 16'd900,   16'd60,  16'd1200,  16'd900,  16'd60},
    {4'd3, 16'd0,     16'd500, 16'd1200,  16'd900,  16'd60},
    {4'd3, 16'd900,   16'd60,  16'd1200,  16'd900,  16'd60},
    {4'd3, 16'd32767, 16'd70,  16'd32767, 16'd900,  16'd70},
    {4'd7, 16'd5,     16'd1,   16'd5,     16'd5,    16'd1},
    {4'd3, 16'd1,     16'd0,   16'd32767, 16'd1,    16'd70}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] kind, input logic [3:0] ch, output logic [15:0] d);
    host_addr = {kind, ch};
    #1;
    d = host_rdata;
  endtask

  task automatic sample_one(input int ch, input logic [15:0] v, input logic [15:0] i);
    @(negedge clk);
    vin_bus = '0; iin_bus = '0; tin_bus = '0;
    vin_bus[ch*16 +: 16] = v;
    iin_bus[ch*16 +: 16] = i;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    vin_bus = '0; iin_bus = '0;
  endtask

  task automatic hwrite(input logic [1:0] kind, input logic [3:0] ch, input logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = {kind, ch}; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(KVM, 4'd0, d);  chk("R1 vmin rail0", d, 16'h7FFF);
    rd(KVM, 4'd15, d); chk("R1 vmin rail15", d, 16'h7FFF);
    rd(KVP, 4'd0, d);  chk("R1 vpeak rail0", d, 16'h0000);
    rd(KIP, 4'd8, d);  chk("R1 ipeak rail8", d, 16'h0000);
    rd(KTP, 4'd4, d);  chk("R1 tpeak sensor4", d, 16'h0000);

    // table walk: R2, R3, R4; entry 3 has a dead rail (R5)
    for (int n = 0; n < NV; n++) begin
      logic [83:0] e;
      e = VEC[n];
      sample_one(int'(e[83:80]), e[79:64], e[63:48]);
      rd(KVP, e[83:80], d); chk((n == 3) ? "R5 vpeak" : "R2 vpeak", d, e[47:32]);
      rd(KVM, e[83:80], d); chk((n == 3) ? "R5 vmin"  : "R3 vmin",  d, e[31:16]);
      rd(KIP, e[83:80], d); chk((n == 3) ? "R5 ipeak" : "R4 ipeak", d, e[15:0]);
    end

    // R6 temperature peak, no disable rule
    @(negedge clk);
    tin_bus = '0; tin_bus[2*16 +: 16] = 16'd2500; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
    rd(KTP, 4'd2, d); chk("R6 tpeak rise", d, 16'd2500);
    tin_bus[2*16 +: 16] = 16'd2400; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
    rd(KTP, 4'd2, d); chk("R6 tpeak lower ignored", d, 16'd2500);
    tin_bus[2*16 +: 16] = 16'd2600; tin_bus[4*16 +: 16] = 16'd3000; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0; tin_bus = '0;
    rd(KTP, 4'd2, d); chk("R6 tpeak sensor2", d, 16'd2600);
    rd(KTP, 4'd4, d); chk("R6 tpeak sensor4", d, 16'd3000);

    // R7 readings without strobe
    @(negedge clk);
    vin_bus[5*16 +: 16] = 16'd777; iin_bus[5*16 +: 16] = 16'd77;
    tin_bus[0 +: 16] = 16'd9999;
    repeat (2) @(negedge clk);
    vin_bus = '0; iin_bus = '0; tin_bus = '0;
    rd(KVP, 4'd5, d); chk("R7 vpeak no strobe", d, 16'd0);
    rd(KVM, 4'd5, d); chk("R7 vmin no strobe", d, 16'h7FFF);
    rd(KIP, 4'd5, d); chk("R7 ipeak no strobe", d, 16'd0);
    rd(KTP, 4'd0, d); chk("R7 tpeak no strobe", d, 16'd0);

    // R8 host re-arm
    hwrite(KVM, 4'd3, 16'h7FFF);
    rd(KVM, 4'd3, d); chk("R8 vmin write", d, 16'h7FFF);
    hwrite(KVP, 4'd3, 16'd0);
    rd(KVP, 4'd3, d); chk("R8 vpeak write", d, 16'd0);
    hwrite(KTP, 4'd1, 16'h0ABC);
    rd(KTP, 4'd1, d); chk("R8 tpeak write", d, 16'h0ABC);
    sample_one(3, 16'd1100, 16'd10);
    rd(KVP, 4'd3, d); chk("R8 vpeak rearmed", d, 16'd1100);
    rd(KVM, 4'd3, d); chk("R8 vmin rearmed", d, 16'd1100);

    // R9 host write and sample on the same register in the same cycle
    @(negedge clk);
    vin_bus[9*16 +: 16] = 16'd2000; iin_bus[9*16 +: 16] = 16'd30; smp_valid = 1'b1;
    host_wr_en = 1'b1; host_addr = {KVP, 4'd9}; host_wdata = 16'd100;
    @(negedge clk);
    smp_valid = 1'b0; host_wr_en = 1'b0; vin_bus = '0; iin_bus = '0;
    rd(KVP, 4'd9, d); chk("R9 host wins vpeak", d, 16'd100);
    rd(KVM, 4'd9, d); chk("R9 sample vmin", d, 16'd2000);
    rd(KIP, 4'd9, d); chk("R9 sample ipeak", d, 16'd30);

    // R10 unmapped temperature address
    hwrite(KTP, 4'd7, 16'h1234);
    rd(KTP, 4'd7, d); chk("R10 unmapped read", d, 16'd0);
    rd(KTP, 4'd2, d); chk("R10 sensor2 untouched", d, 16'd2600);
    rd(KTP, 4'd4, d); chk("R10 sensor4 untouched", d, 16'd3000);
    rd(KTP, 4'd0, d); chk("R10 sensor0 untouched", d, 16'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule